// File: doc/BRIEF.md
# Rotate-Carry Add-XOR Pseudo-Random Generator

This block produces a pseudo-random sequence of words, each as wide as the parameter `W`. On every enabled clock the state is rotated left by one place. The bit that leaves the top is fed into an addition with a programmable addend, where it acts as the carry-in at bit 0. The sum is then XORed with a programmable mask. Unlike a linear-tap shift register, the all-zero word lies on the cycle. With a suitable addend and mask pair, the state visits every one of the 2^W values before it repeats.

Both constants are held in registers. They can be changed only while stepping is paused, so a running sequence never sees a constant change part-way through. A seed port sets the state directly, and it wins over a step requested in the same cycle. A one-cycle wrap flag marks each step that lands on zero. Counting the steps between two flags therefore gives the period of the selected pair. Only pairs in which both constants are odd can reach the full period. Two such pairs at W=16 are 0x778B/0x4A8B and 0x7F25/0x00DB.

Top module: `sax_prng`

## Requirements
- R1: After a synchronous reset the state is zero and the wrap flag is low. The addend holds `ADD_RST` and the mask holds `XOR_RST`, which default to 0x778B and 0x4A8B. The first step from reset therefore yields 0x3D00.
- R2: A step replaces the state with ((state shifted left by one, top bit dropped) + old top bit + addend) XOR mask, kept to W bits.
- R3: After a step, bit 0 of the state equals the old top bit XOR bit 0 of the addend XOR bit 0 of the mask.
- R4: While `seed_load` is high the next state is `seed_val`, whatever `step_en` is, and the wrap flag is low in the following cycle.
- R5: `add_load` and `xor_load` take effect only while `step_en` is low. When `step_en` is high they are ignored, and the constants keep their old values for the steps that follow.
- R6: With `step_en` low and `seed_load` low the state holds its value.
- R7: `wrap_o` is high for exactly the one cycle after a step that produced state zero, and is low otherwise. A seed load of zero does not raise it.
- R8: With the pair 0x778B/0x4A8B, and also with 0x7F25/0x00DB, starting from zero, the wrap flag rises again after exactly 65536 steps at W=16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| step_en | input | 1 | Advance the sequence by one step |
| seed_load | input | 1 | Load `seed_val` into the state; overrides stepping |
| seed_val | input | W | Seed word |
| add_load | input | 1 | Load `add_val` into the addend; honoured only when `step_en` is low |
| add_val | input | W | New addend |
| xor_load | input | 1 | Load `xor_val` into the mask; honoured only when `step_en` is low |
| xor_val | input | W | New mask |
| state_o | output | W | Current generator state |
| wrap_o | output | 1 | One-cycle pulse after a step that produced zero |

## Verification
The whole of the state is visible on `state_o`, so a wrong next-state value shows on the port in the cycle right after the faulty step. A corrupted addend or mask register stays hidden until the next step, then appears at once as a wrong word. The bench computes each word with an independent rotate-based model. A subtle fault, such as a lost carry or a wrong mask bit that only matters for some states, may leave single steps looking right. Such a fault still breaks the full-period run, where the 65536-step count between wrap pulses comes out wrong or the pulse never appears.

// File: rtl/sax_pkg.sv
package sax_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_SEED = 2'd1,
        ACT_STEP = 2'd2
    } sax_act_e;

endpackage

// File: rtl/sax_const_reg.sv
module sax_const_reg #(
    parameter int          W       = 16,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld,
    input  logic         lock,
    input  logic [W-1:0] val,
    output logic [W-1:0] q
);
    logic [W-1:0] c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (ld && !lock) begin
            c_d = val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= RST_VAL;
        end else begin
            c_q <= c_d;
        end
    end

    assign q = c_q;
endmodule

// File: rtl/sax_step.sv
module sax_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] add_c,
    input  logic [W-1:0] xor_c,
    output logic [W-1:0] nxt,
    output logic         nxt_zero
);
    logic         carry_in;
    logic [W-1:0] shifted;
    logic [W-1:0] sum;

    always_comb begin
        carry_in = cur[W-1];
        shifted  = {cur[W-2:0], 1'b0};
        sum      = shifted + add_c + W'(carry_in);
        nxt      = sum ^ xor_c;
        nxt_zero = (nxt == '0);
    end
endmodule

// File: rtl/sax_ctrl.sv
module sax_ctrl
    import sax_pkg::*;
(
    input  logic     seed_load,
    input  logic     step_en,
    output sax_act_e act
);
    always_comb begin
        if (seed_load) begin
            act = ACT_SEED;
        end else if (step_en) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end
endmodule

// File: rtl/sax_prng.sv
module sax_prng
    import sax_pkg::*;
#(
    parameter int           W       = 16,
    parameter logic [W-1:0] ADD_RST = W'(16'h778B),
    parameter logic [W-1:0] XOR_RST = W'(16'h4A8B)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step_en,
    input  logic         seed_load,
    input  logic [W-1:0] seed_val,
    input  logic         add_load,
    input  logic [W-1:0] add_val,
    input  logic         xor_load,
    input  logic [W-1:0] xor_val,
    output logic [W-1:0] state_o,
    output logic         wrap_o
);
    typedef struct packed {
        logic [W-1:0] state;
        logic         wrap;
    } regs_t;

    regs_t        r_d, r_q;
    logic [W-1:0] add_q, xor_q;
    logic [W-1:0] step_nxt;
    logic         step_zero;
    sax_act_e     act;

    sax_const_reg #(.W(W), .RST_VAL(ADD_RST)) u_add (
        .clk(clk), .rst(rst), .ld(add_load), .lock(step_en),
        .val(add_val), .q(add_q)
    );

    sax_const_reg #(.W(W), .RST_VAL(XOR_RST)) u_xor (
        .clk(clk), .rst(rst), .ld(xor_load), .lock(step_en),
        .val(xor_val), .q(xor_q)
    );

    sax_step #(.W(W)) u_step (
        .cur(r_q.state), .add_c(add_q), .xor_c(xor_q),
        .nxt(step_nxt), .nxt_zero(step_zero)
    );

    sax_ctrl u_ctrl (
        .seed_load(seed_load), .step_en(step_en), .act(act)
    );

    always_comb begin
        r_d      = r_q;
        r_d.wrap = 1'b0;
        case (act)
            ACT_SEED: r_d.state = seed_val;
            ACT_STEP: begin
                r_d.state = step_nxt;
                r_d.wrap  = step_zero;
            end
            default:  r_d.state = r_q.state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign state_o = r_q.state;
    assign wrap_o  = r_q.wrap;
endmodule

// File: rtl/sax_prng_chk.sv
module sax_prng_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         step_en,
    input logic         seed_load,
    input logic [W-1:0] seed_val,
    input logic [W-1:0] state_o,
    input logic         wrap_o,
    input logic [W-1:0] add_c,
    input logic [W-1:0] xor_c
);
    p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
        seed_load |=> (state_o == $past(seed_val)) && !wrap_o);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!seed_load && !step_en) |=> $stable(state_o));

    p_bit0_r3: assert property (@(posedge clk) disable iff (rst)
        (step_en && !seed_load) |=>
            state_o[0] == ($past(state_o[W-1]) ^ $past(add_c[0]) ^ $past(xor_c[0])));

    p_const_lock_r5: assert property (@(posedge clk) disable iff (rst)
        step_en |=> ($stable(add_c) && $stable(xor_c)));

    p_wrap_zero_r7: assert property (@(posedge clk) disable iff (rst)
        wrap_o |-> (state_o == '0));

    p_wrap_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (seed_load || !step_en) |=> !wrap_o);
endmodule

bind sax_prng sax_prng_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
    .seed_val(seed_val), .state_o(state_o), .wrap_o(wrap_o),
    .add_c(add_q), .xor_c(xor_q)
);

// File: tb/sax_prng_tb.sv
module sax_prng_tb;
    localparam int W      = 16;
    localparam int CLK_PS = 10;
    localparam int NVEC   = 6;
    localparam logic [3*W-1:0] VEC [NVEC] = '{
        {16'hFFFF, 16'h778B, 16'h4A8B},
        {16'h0001, 16'h7F25, 16'h00DB},
        {16'h1234, 16'h0002, 16'h0000},
        {16'h7FFF, 16'h0001, 16'hFFFF},
        {16'hAAAA, 16'h8875, 16'h4A8B},
        {16'h8001, 16'hFFFF, 16'h0001}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         step_en = 1'b0;
    logic         seed_load = 1'b0;
    logic [W-1:0] seed_val = '0;
    logic         add_load = 1'b0;
    logic [W-1:0] add_val = '0;
    logic         xor_load = 1'b0;
    logic [W-1:0] xor_val = '0;
    logic [W-1:0] state_o;
    logic         wrap_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PS/2) clk = ~clk;

    sax_prng #(.W(W)) u_dut (
        .clk(clk), .rst(rst), .step_en(step_en), .seed_load(seed_load),
        .seed_val(seed_val), .add_load(add_load), .add_val(add_val),
        .xor_load(xor_load), .xor_val(xor_val),
        .state_o(state_o), .wrap_o(wrap_o)
    );

    function automatic logic [W-1:0] ref_next(input logic [W-1:0] s,
                                              input logic [W-1:0] a,
                                              input logic [W-1:0] x);
        logic [W-1:0] rot;
        rot = (s << 1) | (s >> (W-1));
        return (rot + a) ^ x;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; step_en = 1'b0; seed_load = 1'b0;
        add_load = 1'b0; xor_load = 1'b0;
        tick(); tick();
        rst = 1'b0;
    endtask

    task automatic set_all(input logic [W-1:0] s, input logic [W-1:0] a,
                           input logic [W-1:0] x);
        step_en = 1'b0;
        seed_load = 1'b1; seed_val = s;
        add_load = 1'b1;  add_val = a;
        xor_load = 1'b1;  xor_val = x;
        tick();
        seed_load = 1'b0; add_load = 1'b0; xor_load = 1'b0;
    endtask

    task automatic period_run(input logic [W-1:0] a, input logic [W-1:0] x,
                              input string req);
        int cnt;
        set_all('0, a, x);
        step_en = 1'b1;
        cnt = 0;
        for (int i = 0; i < 70000; i++) begin
            tick();
            cnt++;
            if (wrap_o) break;
        end
        step_en = 1'b0;
        chk(req, W'(cnt), W'(65536));
        n_chk++;
        if (cnt != 65536) begin
            n_bad++;
            $display("FAIL %s: period actual %0d expected 65536", req, cnt);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] s, a, x, held;
        do_reset();
        // R1 reset state
        chk("R1 state", state_o, 16'h0000);
        chk("R1 wrap", W'(wrap_o), 16'h0000);
        // R1/R2 first step with default constants
        step_en = 1'b1; tick(); step_en = 1'b0;
        chk("R1 first step", state_o, 16'h3D00);
        chk("R7 no wrap", W'(wrap_o), 16'h0000);
        // R2/R3 carry from top bit
        seed_load = 1'b1; seed_val = 16'h8000; tick(); seed_load = 1'b0;
        step_en = 1'b1; tick(); step_en = 1'b0;
        chk("R2 carry step", state_o, 16'h3D07);

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            {s, a, x} = VEC[v];
            set_all(s, a, x);
            step_en = 1'b1; tick(); step_en = 1'b0;
            chk("R2 vector", state_o, ref_next(s, a, x));
            chk("R3 bit0", W'(state_o[0]), W'(s[W-1] ^ a[0] ^ x[0]));
        end

        // R4 seed wins over step
        seed_load = 1'b1; seed_val = 16'h1234; step_en = 1'b1;
        tick();
        seed_load = 1'b0; step_en = 1'b0;
        chk("R4 seed priority", state_o, 16'h1234);
        chk("R4 wrap low", W'(wrap_o), 16'h0000);

        // R6 hold
        held = state_o;
        tick(); tick();
        chk("R6 hold", state_o, held);

        // R5 loads ignored while stepping
        do_reset();
        seed_load = 1'b1; seed_val = 16'h0F0F; tick(); seed_load = 1'b0;
        step_en = 1'b1; add_load = 1'b1; add_val = 16'h1111;
        xor_load = 1'b1; xor_val = 16'h0000;
        tick();
        add_load = 1'b0; xor_load = 1'b0;
        s = ref_next(16'h0F0F, 16'h778B, 16'h4A8B);
        chk("R5 ignored same step", state_o, s);
        tick();
        step_en = 1'b0;
        chk("R5 constants kept", state_o, ref_next(s, 16'h778B, 16'h4A8B));

        // R7 seed of zero gives no wrap
        seed_load = 1'b1; seed_val = 16'h0000; tick(); seed_load = 1'b0;
        chk("R7 seed zero no wrap", W'(wrap_o), 16'h0000);
        // R7 step into zero: rotl(0x6980)=0xD300, 0xD300+0x778B=0x4A8B
        seed_load = 1'b1; seed_val = 16'h6980; tick(); seed_load = 1'b0;
        step_en = 1'b1; tick();
        chk("R7 zero state", state_o, 16'h0000);
        chk("R7 wrap high", W'(wrap_o), 16'h0001);
        tick(); step_en = 1'b0;
        chk("R7 wrap one cycle", W'(wrap_o), 16'h0000);
        chk("R7 after zero", state_o, 16'h3D00);

        // R8 full period for two pairs
        period_run(16'h778B, 16'h4A8B, "R8 pair A");
        period_run(16'h7F25, 16'h00DB, "R8 pair B");

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule